// File: doc/BRIEF.md
# Oscillator stabilization wait controller

This block keeps three clock sources (a main oscillator, a sub oscillator and a main PLL) from feeding the chip until each one has waited a programmed number of reference ticks after it starts. The wait is measured by counting only. A ready flag sets when the count is reached, whatever the oscillator is actually doing. The main oscillator and the PLL count ticks of a high-speed reference. The sub oscillator counts ticks of a low-speed reference. Both references arrive as single-cycle tick enables in the block's own clock domain.

A wait starts when software raises a source's enable bit. Hardware also restarts waits on wake-up from two low-power modes. The sub-only mode stops the main oscillator and the PLL and keeps the sub oscillator running. The stop mode halts every source. A software-reset indication skips all waiting and marks the enabled sources ready at once.

While any enabled source is still waiting, the block raises a stall output and withholds clock supply. Each wait length is a 4-bit code held per source, and the code can only be changed while that source is disabled.

Top module: `osc_stab_ctrl`

## Requirements
- R1: With code c, a source's ready flag sets exactly 2^(c+OFFSET) counted ticks after its wait starts. Ticks given in the cycle the wait starts do not count.
- R2: Sources at index 0 (main) and index 2 (PLL) count only `hs_tick_i`. The source at index 1 (sub) counts only `ls_tick_i`.
- R3: A 0-to-1 change of `src_en_i[k]` clears `ready_o[k]` and starts source k's count from zero in the next cycle.
- R4: `stall_o` is high exactly while some enabled source is waiting. It falls in the same cycle that the last ready flag sets. `clk_gate_o` is low whenever `stall_o` is high or a low-power mode is active.
- R5: A `sub_mode_i` pulse in run mode clears `ready_o[0]` and `ready_o[2]` in the next cycle and leaves `ready_o[1]` unchanged. A later `wake_i` pulse restarts full waits for the main oscillator and the PLL only.
- R6: A `stop_mode_i` pulse in run mode clears every ready flag in the next cycle. A later `wake_i` pulse restarts full waits for every enabled source.
- R7: A `sw_reset_i` pulse sets the ready flag of every enabled source in the next cycle, with no wait, and clears `stall_o`.
- R8: A code write (`code_we_i[k]` with `code_i`) is accepted only while `src_en_i[k]` is 0. A write made while the source is enabled leaves the wait length unchanged.
- R9: Clearing `src_en_i[k]` during a wait aborts it: in the next cycle `ready_o[k]` is 0 and source k no longer stalls. The next enable counts from zero.
- R10: After `rst_i`, all ready flags are 0, `stall_o` is 0, `clk_gate_o` is 1 and every code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hs_tick_i | input | 1 | High-speed reference tick enable |
| ls_tick_i | input | 1 | Low-speed reference tick enable |
| src_en_i | input | 3 | Software enable per source (0 main, 1 sub, 2 PLL) |
| code_we_i | input | 3 | Per-source write strobe for the wait code |
| code_i | input | CODE_W | Wait code data shared by the strobes |
| sub_mode_i | input | 1 | Pulse: enter the mode that keeps only the sub oscillator |
| stop_mode_i | input | 1 | Pulse: enter the stop mode (takes priority over sub_mode_i) |
| wake_i | input | 1 | Pulse: wake-up event from the active low-power mode |
| sw_reset_i | input | 1 | Pulse: software-reset indication, skips waiting |
| ready_o | output | 3 | Per-source ready flag |
| stall_o | output | 1 | High while any enabled source is waiting |
| clk_gate_o | output | 1 | High when clock supply may run |

## Verification
The bench builds the block with OFFSET set to 0, so a code c gives a wait of 2^c ticks. This makes codes 0 to 4 short enough to count every tick to the exact terminal value, on both reference inputs, with spaced tick patterns. The unused reference is held high during each measurement, so it is clear which reference a source counts. The same short waits let the directed tests do mode entry, wake, abort, locked-code writes and the software-reset bypass with several sources in flight, all within a few hundred cycles.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_MAIN = 0;
  localparam int SRC_SUB  = 1;
  localparam int SRC_PLL  = 2;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_SUBONLY = 2'd1,
    PM_STOP    = 2'd2
  } pmode_e;

  // sources halted by each low-power mode
  localparam logic [NSRC-1:0] SUBONLY_MASK = 3'b101;
  localparam logic [NSRC-1:0] STOP_MASK    = 3'b111;
endpackage

// File: rtl/osc_pm_seq.sv
module osc_pm_seq
  import osc_stab_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            sub_mode_i,
  input  logic            stop_mode_i,
  input  logic            wake_i,
  input  logic            bypass_i,
  output logic [NSRC-1:0] halt_o,
  output logic [NSRC-1:0] resume_o,
  output logic            lp_active_o
);
  pmode_e mode_q, mode_d;

  always_comb begin
    mode_d   = mode_q;
    halt_o   = '0;
    resume_o = '0;
    unique case (mode_q)
      PM_RUN: begin
        if (stop_mode_i) begin
          mode_d = PM_STOP;
          halt_o = STOP_MASK;
        end else if (sub_mode_i) begin
          mode_d = PM_SUBONLY;
          halt_o = SUBONLY_MASK;
        end
      end
      PM_SUBONLY: if (wake_i) begin
        mode_d   = PM_RUN;
        resume_o = SUBONLY_MASK;
      end
      PM_STOP: if (wake_i) begin
        mode_d   = PM_RUN;
        resume_o = STOP_MASK;
      end
      default: mode_d = PM_RUN;
    endcase
    if (bypass_i) begin
      mode_d   = PM_RUN;
      halt_o   = '0;
      resume_o = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) mode_q <= PM_RUN;
    else       mode_q <= mode_d;
  end

  assign lp_active_o = (mode_q != PM_RUN);

  // R5/R6: a wake in run mode is not a mode change
  p_wake_in_run_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q == PM_RUN && !sub_mode_i && !stop_mode_i) |=> (mode_q == PM_RUN));
  p_mode_legal_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q != 2'd3));
endmodule

// File: rtl/osc_wait_unit.sv
module osc_wait_unit #(
  parameter int CODE_W = 4,
  parameter int OFFSET = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              code_we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              halt_i,
  input  logic              resume_i,
  input  logic              bypass_i,
  output logic              ready_o,
  output logic              waiting_o
);
  localparam int CNT_W = (1 << CODE_W) + OFFSET;

  logic              en_q;
  logic              halted_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  term;
  logic [CNT_W-1:0]  cnt_inc;

  assign term    = {{(CNT_W-1){1'b0}}, 1'b1} << (int'(code_q) + OFFSET);
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_q <= '0;
    end else if (code_we_i && !en_i) begin
      code_q <= code_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q      <= 1'b0;
      halted_q  <= 1'b0;
      cnt_q     <= '0;
      ready_o   <= 1'b0;
      waiting_o <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        halted_q  <= 1'b0;
        cnt_q     <= '0;
        ready_o   <= 1'b0;
        waiting_o <= 1'b0;
      end else if (bypass_i) begin
        halted_q  <= 1'b0;
        cnt_q     <= '0;
        ready_o   <= 1'b1;
        waiting_o <= 1'b0;
      end else if (halt_i) begin
        halted_q  <= 1'b1;
        cnt_q     <= '0;
        ready_o   <= 1'b0;
        waiting_o <= 1'b0;
      end else if (halted_q) begin
        if (resume_i) begin
          halted_q  <= 1'b0;
          waiting_o <= 1'b1;
        end
      end else if (!en_q) begin
        cnt_q     <= '0;
        ready_o   <= 1'b0;
        waiting_o <= 1'b1;
      end else if (waiting_o && tick_i) begin
        if (cnt_inc == term) begin
          cnt_q     <= '0;
          ready_o   <= 1'b1;
          waiting_o <= 1'b0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  p_start_wait_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !en_q && !bypass_i && !halt_i) |=> (waiting_o && !ready_o));
  p_count_done_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && en_q && waiting_o && tick_i && !bypass_i && !halt_i && cnt_inc == term)
      |=> ready_o);
  p_hold_without_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && en_q && waiting_o && !tick_i && !bypass_i && !halt_i) |=> waiting_o);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!ready_o && !waiting_o));
  p_bypass_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && bypass_i) |=> (ready_o && !waiting_o));
  p_code_locked_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> $stable(code_q));
  p_excl_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ready_o && waiting_o));
endmodule

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl
  import osc_stab_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int OFFSET = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hs_tick_i,
  input  logic              ls_tick_i,
  input  logic [2:0]        src_en_i,
  input  logic [2:0]        code_we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              sub_mode_i,
  input  logic              stop_mode_i,
  input  logic              wake_i,
  input  logic              sw_reset_i,
  output logic [2:0]        ready_o,
  output logic              stall_o,
  output logic              clk_gate_o
);
  logic [NSRC-1:0] halt;
  logic [NSRC-1:0] resume;
  logic [NSRC-1:0] waiting;
  logic            lp_active;

  osc_pm_seq u_seq (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sub_mode_i  (sub_mode_i),
    .stop_mode_i (stop_mode_i),
    .wake_i      (wake_i),
    .bypass_i    (sw_reset_i),
    .halt_o      (halt),
    .resume_o    (resume),
    .lp_active_o (lp_active)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic tick_sel;
    if (k == SRC_SUB) begin : g_ls
      assign tick_sel = ls_tick_i;
    end else begin : g_hs
      assign tick_sel = hs_tick_i;
    end
    osc_wait_unit #(.CODE_W(CODE_W), .OFFSET(OFFSET)) u_wait (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .en_i      (src_en_i[k]),
      .tick_i    (tick_sel),
      .code_we_i (code_we_i[k]),
      .code_i    (code_i),
      .halt_i    (halt[k]),
      .resume_i  (resume[k]),
      .bypass_i  (sw_reset_i),
      .ready_o   (ready_o[k]),
      .waiting_o (waiting[k])
    );
  end

  assign stall_o    = |waiting;
  assign clk_gate_o = !stall_o && !lp_active;

  p_gate_off_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    stall_o |-> !clk_gate_o);
  p_sub_kept_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (sub_mode_i && !stop_mode_i && !lp_active && src_en_i[SRC_SUB] && ready_o[SRC_SUB]
     && !sw_reset_i) |=> ready_o[SRC_SUB]);
  p_stop_clears_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (stop_mode_i && !lp_active && !sw_reset_i) |=> (ready_o == 3'b000 && !clk_gate_o));
endmodule

// File: tb/osc_stab_ctrl_tb_top.sv
module osc_stab_ctrl_tb_top;
  localparam int CODE_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hs = 1'b0, ls = 1'b0;
  logic [2:0]        en = '0, we = '0;
  logic [CODE_W-1:0] code = '0;
  logic              sub_m = 1'b0, stop_m = 1'b0, wake = 1'b0, swr = 1'b0;
  logic [2:0]        ready;
  logic              stall, gate;

  int vec_cnt = 0;
  int mis_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc_stab_ctrl #(.CODE_W(CODE_W), .OFFSET(0)) dut_i (
    .clk_i(clk), .rst_i(rst), .hs_tick_i(hs), .ls_tick_i(ls),
    .src_en_i(en), .code_we_i(we), .code_i(code),
    .sub_mode_i(sub_m), .stop_mode_i(stop_m), .wake_i(wake), .sw_reset_i(swr),
    .ready_o(ready), .stall_o(stall), .clk_gate_o(gate)
  );

  // [11:8] source, [7:4] code, [3:0] idle cycles between ticks
  localparam logic [11:0] VEC [6] = '{12'h020, 12'h131, 12'h210,
                                      12'h000, 12'h242, 12'h103};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      mis_cnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_tick(input int src, input logic v);
    if (src == 1) ls = v;
    else          hs = v;
  endtask

  task automatic wcode(input int src, input int c);
    we[src] = 1'b1;
    code = CODE_W'(c);
    step();
    we = '0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    step();
    s = 1'b0;
  endtask

  // enable src, deliver its ticks with gaps, return ticks applied when ready shows
  task automatic run_src(input int src, input int gap, output int n);
    int ph = 0;
    n = 0;
    hs = (src == 1);
    ls = (src != 1);
    en[src] = 1'b1;
    for (int g = 0; g < 5000; g++) begin
      step();
      if (ready[src]) break;
      if (g == 0) chk(stall == 1'b1, "R4 stall during wait", stall, 1);
      if (ph == 0) begin
        set_tick(src, 1'b1);
        n++;
      end else begin
        set_tick(src, 1'b0);
      end
      ph = (ph >= gap) ? 0 : ph + 1;
    end
    hs = 1'b0;
    ls = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mis_cnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, mis_cnt);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R10 reset state
    chk(ready == 3'b000, "R10 ready after reset", ready, 0);
    chk(stall == 1'b0, "R10 stall after reset", stall, 0);
    chk(gate == 1'b1, "R10 gate after reset", gate, 1);
    run_src(0, 0, n);
    chk(n == 1, "R10 default code gives one tick", n, 1);
    en = '0;
    step();

    // R1/R2: vector table
    foreach (VEC[i]) begin
      int src, c, gap;
      src = int'(VEC[i][11:8]);
      c   = int'(VEC[i][7:4]);
      gap = int'(VEC[i][3:0]);
      en = '0;
      step();
      wcode(src, c);
      run_src(src, gap, n);
      chk(n == (1 << c), "R1 R2 ticks to ready", n, 1 << c);
      chk(stall == 1'b0 && gate == 1'b1, "R4 stall clear after ready", stall, 0);
    end
    en = '0;
    step();

    // R3: re-enable restarts wait and clears ready
    wcode(0, 1);
    run_src(0, 0, n);
    en[0] = 1'b0;
    step();
    en[0] = 1'b1;
    step();
    chk(ready[0] == 1'b0 && stall == 1'b1, "R3 rise clears ready", ready[0], 0);
    en = '0;
    step();

    // R8: write while enabled ignored
    wcode(0, 2);
    en[0] = 1'b1;
    step();
    wcode(0, 5);
    en = '0;
    step();
    step();
    run_src(0, 0, n);
    chk(n == 4, "R8 write while enabled ignored", n, 4);
    en = '0;
    step();
    wcode(0, 1);
    run_src(0, 0, n);
    chk(n == 2, "R8 write while disabled accepted", n, 2);
    en = '0;
    step();

    // R9: abort mid-count
    wcode(0, 3);
    en[0] = 1'b1;
    hs = 1'b1;
    repeat (4) step();
    en[0] = 1'b0;
    step();
    chk(ready[0] == 1'b0 && stall == 1'b0, "R9 abort clears", stall, 0);
    hs = 1'b0;
    run_src(0, 0, n);
    chk(n == 8, "R9 count restarts from zero", n, 8);
    en = '0;
    step();

    // R4: stall drops the cycle the last flag sets
    wcode(0, 1);
    wcode(2, 2);
    en = 3'b101;
    hs = 1'b1;
    for (int c = 1; c <= 5; c++) begin
      step();
      chk(stall == (c < 5), "R4 stall tracks last ready", stall, int'(c < 5));
      chk(ready == ((c >= 5) ? 3'b101 : (c >= 3) ? 3'b001 : 3'b000),
          "R4 ready sequence", ready, (c >= 5) ? 5 : (c >= 3) ? 1 : 0);
    end
    hs = 1'b0;
    en = '0;
    step();

    // R5: sub-only mode
    wcode(1, 1);
    en = 3'b111;
    hs = 1'b1;
    ls = 1'b1;
    repeat (6) step();
    chk(ready == 3'b111, "R5 all ready before mode", ready, 7);
    hs = 1'b0;
    ls = 1'b0;
    pulse(sub_m);
    chk(ready == 3'b010, "R5 sub-only clears main and pll", ready, 2);
    chk(gate == 1'b0, "R4 gate off in low power", gate, 0);
    pulse(wake);
    chk(ready == 3'b010 && stall == 1'b1, "R5 wake reruns main and pll", ready, 2);
    hs = 1'b1;
    step();
    step();
    chk(ready == 3'b011, "R5 main ready after rerun", ready, 3);
    step();
    step();
    chk(ready == 3'b111 && gate == 1'b1, "R5 pll ready after rerun", ready, 7);
    hs = 1'b0;

    // R6: stop mode
    pulse(stop_m);
    chk(ready == 3'b000 && gate == 1'b0, "R6 stop clears all", ready, 0);
    pulse(wake);
    chk(ready == 3'b000 && stall == 1'b1, "R6 wake reruns all", ready, 0);
    hs = 1'b1;
    ls = 1'b1;
    repeat (4) step();
    chk(ready == 3'b111 && stall == 1'b0, "R6 all ready after rerun", ready, 7);
    hs = 1'b0;
    ls = 1'b0;

    // R7: software reset bypass
    pulse(stop_m);
    pulse(wake);
    chk(stall == 1'b1, "R7 waiting before bypass", stall, 1);
    pulse(swr);
    chk(ready == 3'b111 && stall == 1'b0, "R7 bypass makes ready", ready, 7);
    en = 3'b000;
    step();
    en = 3'b010;
    step();
    pulse(swr);
    chk(ready == 3'b010, "R7 only enabled sources ready", ready, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, mis_cnt);
    $finish;
  end
endmodule